// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front End

This block sits between a simple 32-bit register bus and an I2C master engine. Software reaches eight word registers through a 3-bit word index. Word 0 is a shared data port: a write loads the transmit queue and a read drains the receive queue. The remaining words hold a status view, a control word, the two SCL phase dividers, the own-address field and the fill level of each queue.

The engine takes command words from the head of the transmit queue and pushes received bytes into the receive queue. It reports its events and live conditions on dedicated inputs. The block turns those inputs into status bits and ANDs them with the per-source enables from the control word. The results are ORed into a single interrupt line.

Setting the reset bit in the control word flushes both queues and clears the sticky events. It also holds the engine in reset for a fixed number of cycles. The bit then clears itself, so software can poll it to see when the reset is finished.

Top module: `i2c_ctl_regs`

## Requirements
- R1: After reset: control reads 0 (all enables off, reset bit clear); both dividers read 0x3FF; own address reads 0; both levels read 0; `irq` and `eng_reset` are low; `tx_avail` is low.
- R2: A write to word 0 appends `bus_wdata[9:0]` to the transmit queue. `tx_word` shows the oldest entry while `tx_avail` is high, and each `tx_pop` moves to the next entry in write order. Word 7 reads the entry count.
- R3: A write to word 0 while the transmit queue holds DEPTH entries is discarded: the level stays at DEPTH and the value never reaches `tx_word`.
- R4: `rx_push` appends `rx_byte` to the receive queue. A read of word 0 returns the oldest byte in bits 7:0, with zeros above, and removes it. Word 6 reads the entry count.
- R5: A read of word 0 with an empty receive queue returns 0 and changes nothing. An `rx_push` while the queue is full is dropped.
- R6: Status (word 1) bit positions are: 0 done, 1 arbitration lost, 2 no-ack, 3 data request, 5 busy, 6 SCL line, 7 SDA line, 8 RX full, 9 RX empty, 10 TX full, 11 TX empty. All other bits read 0.
- R7: A pulse on `ev_done` or `ev_arb_lost` sets status bit 0 or bit 1. The bit stays set until a status write with a 1 in that position. Writing a 0 leaves it unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R8: Status bits 2, 3 and 5 follow `st_nack`, `st_data_req` and `st_busy` directly, with no memory.
- R9: Control bits 7:0 are enables that read back as written. `irq` is the OR of the enabled conditions: bit 0 done, 1 arbitration lost, 2 no-ack, 3 data request, 5 RX full, 6 RX not empty, 7 TX full. Bit 4 is stored but has no condition.
- R10: Writing 1 to control bit 8 starts a soft reset. Bit 8 then reads 1 and `eng_reset` is high for RST_CYCLES cycles. During that time both queues are emptied and the done and arbitration-lost bits are cleared. Bit 8 then returns to 0 by itself, and the enables are kept.
- R11: Words 3 and 4 keep `bus_wdata[9:0]` and drive `scl_low_div` and `scl_high_div`. Word 5 keeps `bus_wdata[6:0]` and drives `own_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| reg_idx | input | 3 | Word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| ev_done | input | 1 | Engine pulse: transaction complete |
| ev_arb_lost | input | 1 | Engine pulse: arbitration lost |
| st_nack | input | 1 | Engine level: no acknowledge seen |
| st_data_req | input | 1 | Engine level: engine needs data |
| st_busy | input | 1 | Engine level: bus active |
| scl_line | input | 1 | Sampled SCL |
| sda_line | input | 1 | Sampled SDA |
| tx_pop | input | 1 | Engine consumes the transmit head |
| tx_avail | output | 1 | Transmit queue not empty |
| tx_word | output | TXW | Transmit queue head |
| rx_push | input | 1 | Engine delivers a byte |
| rx_byte | input | 8 | Received byte |
| eng_reset | output | 1 | Soft reset to the engine |
| scl_low_div | output | 10 | SCL low-phase divider |
| scl_high_div | output | 10 | SCL high-phase divider |
| own_addr | output | 7 | Own address |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check four things. A transmit write into a full queue leaves the level unchanged. Event pulses always set their sticky bit, and a clearing write removes it. A read from an empty receive queue returns zero. The soft reset flushes both queues and ends after the programmed count. Some behaviours need the bench's scenarios instead: the first-in-first-out order on both queues, the exact bit position of each status field, the one-to-one pairing of each enable with its condition on `irq`, the read-back of the reset bit while the reset is running, and the survival of the enables across a soft reset.

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs #(
  parameter int DEPTH = 4,
  parameter int TXW = 10,
  parameter int RST_CYCLES = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [2:0]     reg_idx,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic           ev_done,
  input  logic           ev_arb_lost,
  input  logic           st_nack,
  input  logic           st_data_req,
  input  logic           st_busy,
  input  logic           scl_line,
  input  logic           sda_line,
  input  logic           tx_pop,
  output logic           tx_avail,
  output logic [TXW-1:0] tx_word,
  input  logic           rx_push,
  input  logic [7:0]     rx_byte,
  output logic           eng_reset,
  output logic [9:0]     scl_low_div,
  output logic [9:0]     scl_high_div,
  output logic [6:0]     own_addr,
  output logic           irq
);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int RCW = $clog2(RST_CYCLES + 1);

  logic [TXW-1:0] txm [DEPTH];
  logic [7:0]     rxm [DEPTH];
  logic [PW-1:0]  tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0]  tx_cnt, rx_cnt;
  logic           done_q, arb_q, srst;
  logic [RCW-1:0] rcnt;
  logic [7:0]     en;
  logic           unused_hi;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire wr_en    = bus_sel & bus_wr;
  wire rd_en    = bus_sel & ~bus_wr;
  wire tx_full  = (tx_cnt == CW'(DEPTH));
  wire tx_empty = (tx_cnt == '0);
  wire rx_full  = (rx_cnt == CW'(DEPTH));
  wire rx_empty = (rx_cnt == '0);
  wire tx_put   = wr_en && reg_idx == 3'd0 && !tx_full && !srst;
  wire tx_take  = tx_pop && !tx_empty && !srst;
  wire rx_put   = rx_push && !rx_full && !srst;
  wire rx_take  = rd_en && reg_idx == 3'd0 && !rx_empty && !srst;
  wire st_wr    = wr_en && reg_idx == 3'd1;

  wire [11:0] status = {tx_empty, tx_full, rx_empty, rx_full, sda_line, scl_line,
                        st_busy, 1'b0, st_data_req, st_nack, arb_q, done_q};
  wire [7:0] cond = {tx_full, !rx_empty, rx_full, 1'b0, st_data_req, st_nack, arb_q, done_q};

  assign irq       = |(en & cond);
  assign tx_avail  = !tx_empty;
  assign tx_word   = txm[tx_rp];
  assign eng_reset = srst;
  assign unused_hi = ^bus_wdata[31:10];

  always_ff @(posedge clk) begin
    if (tx_put) txm[tx_wp] <= bus_wdata[TXW-1:0];
    if (rx_put) rxm[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (srst) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_put)  tx_wp <= nxt(tx_wp);
      if (tx_take) tx_rp <= nxt(tx_rp);
      if (rx_put)  rx_wp <= nxt(rx_wp);
      if (rx_take) rx_rp <= nxt(rx_rp);
      tx_cnt <= tx_cnt + CW'(tx_put) - CW'(tx_take);
      rx_cnt <= rx_cnt + CW'(rx_put) - CW'(rx_take);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      arb_q  <= 1'b0;
    end else if (srst) begin
      done_q <= 1'b0;
      arb_q  <= 1'b0;
    end else begin
      if (ev_done) done_q <= 1'b1;
      else if (st_wr && bus_wdata[0]) done_q <= 1'b0;
      if (ev_arb_lost) arb_q <= 1'b1;
      else if (st_wr && bus_wdata[1]) arb_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0;
      srst <= 1'b0;
      rcnt <= '0;
      scl_low_div <= 10'h3FF;
      scl_high_div <= 10'h3FF;
      own_addr <= '0;
    end else begin
      if (srst) begin
        if (rcnt == RCW'(RST_CYCLES - 1)) srst <= 1'b0;
        else rcnt <= rcnt + 1'b1;
      end
      if (wr_en) begin
        case (reg_idx)
          3'd2: begin
            en <= bus_wdata[7:0];
            if (bus_wdata[8] && !srst) begin
              srst <= 1'b1;
              rcnt <= '0;
            end
          end
          3'd3: scl_low_div <= bus_wdata[9:0];
          3'd4: scl_high_div <= bus_wdata[9:0];
          3'd5: own_addr <= bus_wdata[6:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd_en) begin
      case (reg_idx)
        3'd0: bus_rdata <= rx_take ? {24'b0, rxm[rx_rp]} : 32'b0;
        3'd1: bus_rdata <= {20'b0, status};
        3'd2: bus_rdata <= {23'b0, srst, en};
        3'd3: bus_rdata <= {22'b0, scl_low_div};
        3'd4: bus_rdata <= {22'b0, scl_high_div};
        3'd5: bus_rdata <= {25'b0, own_addr};
        3'd6: bus_rdata <= {{(32-CW){1'b0}}, rx_cnt};
        default: bus_rdata <= {{(32-CW){1'b0}}, tx_cnt};
      endcase
    end
  end

  // R3
  tx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == 3'd0 && tx_full && !tx_pop && !srst) |=> tx_cnt == $past(tx_cnt));

  // R7
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && !srst) |=> done_q);

  // R7
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && bus_wdata[0] && !ev_done) |=> !done_q);

  // R5
  rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_idx == 3'd0 && rx_empty && !rx_push) |=> (bus_rdata == 32'b0 && rx_cnt == '0));

  // R10
  srst_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (tx_cnt == '0 && rx_cnt == '0));

  // R10
  srst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srst && rcnt == RCW'(RST_CYCLES - 1)) |=> !srst);
endmodule

// File: tb/test_i2c_ctl_regs.sv
`timescale 1ns/1ps
module test_i2c_ctl_regs;
  logic clk = 0, rst_n = 0;
  logic sel = 0, wr = 0;
  logic [2:0] idx = 0;
  logic [31:0] wdata = 0, rdata;
  logic ev_done = 0, ev_arb = 0, nack = 0, dreq = 0, busy = 0, scl = 1, sda = 1;
  logic tx_pop = 0, tx_avail, rx_push = 0, eng_reset, irq;
  logic [9:0] tx_word, lo_div, hi_div;
  logic [7:0] rx_byte = 0;
  logic [6:0] own;
  int checks = 0, errors = 0;
  logic rd_seen = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  i2c_ctl_regs i_i2c_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .reg_idx(idx),
    .bus_wdata(wdata), .bus_rdata(rdata), .ev_done(ev_done), .ev_arb_lost(ev_arb),
    .st_nack(nack), .st_data_req(dreq), .st_busy(busy), .scl_line(scl), .sda_line(sda),
    .tx_pop(tx_pop), .tx_avail(tx_avail), .tx_word(tx_word), .rx_push(rx_push),
    .rx_byte(rx_byte), .eng_reset(eng_reset), .scl_low_div(lo_div),
    .scl_high_div(hi_div), .own_addr(own), .irq(irq));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= sel & ~wr & rst_n;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk(rdata, 32'hDEAD, "scoreboard underflow");
      else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic bw(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; idx = i; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic br(input logic [2:0] i, input logic [31:0] e, input string t);
    @(negedge clk); sel = 1; wr = 0; idx = i;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); sel = 0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk); rx_push = 1; rx_byte = b;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic pulse(input bit arb, input bit dn);
    @(negedge clk); ev_arb = arb; ev_done = dn;
    @(negedge clk); ev_arb = 0; ev_done = 0;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 R6 reset values
    chk(irq, 0, "R1 irq"); chk(eng_reset, 0, "R1 eng_reset"); chk(tx_avail, 0, "R1 tx_avail");
    br(2, 0, "R1 control"); br(3, 32'h3FF, "R1 low div"); br(4, 32'h3FF, "R1 high div");
    br(5, 0, "R1 own addr"); br(6, 0, "R1 rx level"); br(7, 0, "R1 tx level");
    br(1, 32'hAC0, "R6 reset status");
    // R11 dividers and address
    bw(3, 32'h1C05); bw(4, 32'h2A7); bw(5, 32'hD5);
    br(3, 32'h005, "R11 low div"); br(4, 32'h2A7, "R11 high div"); br(5, 32'h55, "R11 own");
    chk(lo_div, 10'h005, "R11 low port"); chk(hi_div, 10'h2A7, "R11 high port"); chk(own, 7'h55, "R11 own port");
    // R2 R3 transmit queue
    bw(0, 32'h101); bw(0, 32'h0A5); bw(0, 32'h2FF);
    br(7, 3, "R2 tx level");
    chk(tx_avail, 1, "R2 tx_avail"); chk(tx_word, 10'h101, "R2 head");
    br(1, 32'h2C0, "R6 tx not empty");
    bw(0, 32'h033); bw(0, 32'h3EE);
    br(7, 4, "R3 tx level at full");
    br(1, 32'h6C0, "R6 tx full");
    bw(2, 32'h80);
    chk(irq, 1, "R9 tx full irq");
    bw(2, 32'h00);
    pop_tx(); chk(tx_word, 10'h0A5, "R2 order 2");
    pop_tx(); chk(tx_word, 10'h2FF, "R2 order 3");
    pop_tx(); chk(tx_word, 10'h033, "R2 order 4");
    pop_tx(); chk(tx_avail, 0, "R3 dropped write absent");
    br(7, 0, "R3 tx level empty");
    // R4 R5 receive queue
    push_rx(8'h11); push_rx(8'h22);
    br(6, 2, "R4 rx level");
    br(1, 32'h8C0, "R6 rx not empty");
    br(0, 32'h11, "R4 rx first"); br(0, 32'h22, "R4 rx second");
    br(0, 0, "R5 empty read"); br(6, 0, "R5 level after empty read");
    for (int k = 0; k < 5; k++) push_rx(8'h40 + 8'(k));
    br(6, 4, "R5 rx full level"); br(1, 32'h9C0, "R6 rx full");
    for (int k = 0; k < 4; k++) br(0, 32'h40 + k, "R5 rx full order");
    br(0, 0, "R5 overflow byte dropped");
    // R7 sticky events
    pulse(0, 1); br(1, 32'hAC1, "R7 done set");
    bw(1, 0); br(1, 32'hAC1, "R7 zero write keeps");
    bw(1, 1); br(1, 32'hAC0, "R7 done cleared");
    pulse(1, 1); br(1, 32'hAC3, "R7 both set");
    bw(1, 1); br(1, 32'hAC2, "R7 arb kept");
    bw(1, 2); br(1, 32'hAC0, "R7 arb cleared");
    // R8 live bits
    nack = 1; br(1, 32'hAC4, "R8 nack");
    dreq = 1; br(1, 32'hACC, "R8 data req");
    busy = 1; br(1, 32'hAEC, "R8 busy");
    nack = 0; dreq = 0; busy = 0; br(1, 32'hAC0, "R8 cleared");
    scl = 0; br(1, 32'hA80, "R6 scl line"); scl = 1;
    // R9 interrupt
    bw(2, 32'h01); br(2, 32'h01, "R9 enable readback"); chk(irq, 0, "R9 idle");
    pulse(0, 1); chk(irq, 1, "R9 done irq");
    bw(1, 1); chk(irq, 0, "R9 done irq cleared");
    bw(2, 32'h04); nack = 1; @(negedge clk); chk(irq, 1, "R9 nack irq");
    nack = 0; @(negedge clk); chk(irq, 0, "R9 nack gone");
    bw(2, 32'h40); push_rx(8'h77); chk(irq, 1, "R9 rx avail irq");
    br(0, 32'h77, "R9 rx data"); @(negedge clk); chk(irq, 0, "R9 rx drained");
    bw(2, 32'h20);
    for (int k = 0; k < 3; k++) push_rx(8'h50 + 8'(k));
    chk(irq, 0, "R9 rx not yet full");
    push_rx(8'h53); chk(irq, 1, "R9 rx full irq");
    for (int k = 0; k < 4; k++) br(0, 32'h50 + k, "R9 rx drain");
    pulse(0, 1); bw(2, 32'h10); chk(irq, 0, "R9 masked done");
    // R10 soft reset
    bw(0, 32'h0F0); push_rx(8'h99);
    bw(2, 32'h103);
    chk(eng_reset, 1, "R10 eng_reset high");
    br(2, 32'h103, "R10 bit reads set");
    repeat (6) @(negedge clk);
    chk(eng_reset, 0, "R10 eng_reset low");
    br(2, 32'h003, "R10 self clear keeps enables");
    br(6, 0, "R10 rx flushed"); br(7, 0, "R10 tx flushed");
    br(1, 32'hAC0, "R10 status after reset");
    chk(tx_avail, 0, "R10 tx_avail"); chk(irq, 0, "R10 irq");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk(exp_q.size(), 0, "scoreboard leftover");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule